// File: doc/BRIEF.md
# RISC-V Integer ALU with Operation Decoder

This block is the arithmetic core of a 32-bit integer pipeline. It is purely combinational and has two halves. A decoder reads the major opcode, the three-bit minor function field and one alternate-operation bit, which is bit 5 of the instruction's upper function field, and turns them into an internal operation. A 32-bit datapath then applies that operation to operands A and B.

Operands arrive already prepared. Immediates have been sign-extended upstream, and an upper-immediate value is delivered fully formed on B. Branch decisions are made elsewhere, so branch opcodes produce a zero result.

The unit covers register-register arithmetic, register-immediate arithmetic, address sums for memory accesses and PC-relative sums, and the upper-immediate pass-through.

Top module: `rv_int_alu`

## Requirements
- R1: For opcode 0110011, the minor field selects the operation: 000 add, or subtract (A-B) when the alternate bit is 1; 001 left shift; 010 signed less-than; 011 unsigned less-than; 100 XOR; 101 right shift; 110 OR; 111 AND.
- R2: For opcode 0010011, the same minor-field mapping applies with B as the immediate. With minor field 000 the alternate bit is ignored, so the result is always A+B.
- R3: Every shift moves A by the amount in B[4:0]. B[31:5] has no effect on a shift result.
- R4: With minor field 101, an alternate bit of 1 selects an arithmetic right shift that fills with A[31], and 0 selects a logical right shift that fills with zeros. This holds for both opcode 0110011 and opcode 0010011. Example: A=0x92153524, B=0xffffde81, arithmetic shift gives 0xc90a9a92.
- R5: A less-than result is 0x00000001 when the comparison holds and 0x00000000 otherwise. Minor field 010 compares signed values and 011 compares unsigned values.
- R6: Load opcode 0000011 and store opcode 0100011 give A+B, whatever the minor field and the alternate bit.
- R7: Opcode 0110111 gives B unchanged.
- R8: Opcodes 0010111, 1101111 and 1100111 give A+B, wrapping modulo 2^32.
- R9: Branch opcode 1100011 and every opcode not listed in R1 to R8 give 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode of the instruction |
| funct3 | input | 3 | Minor function field |
| alt_sel | input | 1 | Alternate-operation bit (bit 5 of the upper function field) |
| op_a | input | 32 | First operand; the value that is shifted |
| op_b | input | 32 | Second operand, immediate, or shift amount |
| result | output | 32 | Operation result |

## Verification
Two functions meet in one step: the decoder's reading of the alternate bit and the datapath's choice between adder and shifter. The same alternate bit must subtract for a register-register add, be ignored for an immediate add, and switch the fill for both kinds of right shift.

The bench provokes this by applying alt_sel=1 under all of those opcode and minor-field combinations in consecutive cycles, with operands whose sign bit is set. It judges each result against a behavioural reference model. Random sweeps then mix every opcode with random alternate bits and random high bits of B.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [3:0] {
    K_ZERO, K_ADD, K_SUB, K_SLL, K_SLT, K_SLTU,
    K_XOR, K_SRL, K_SRA, K_OR, K_AND, K_PASSB
  } alu_kind_e;

  function automatic logic [XLEN-1:0] f_rev(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  function automatic logic f_less(input logic [XLEN-1:0] a,
                                  input logic [XLEN-1:0] b,
                                  input logic            sgn);
    logic flip;
    flip = sgn & (a[XLEN-1] ^ b[XLEN-1]);
    return flip ? a[XLEN-1] : (a < b);
  endfunction
endpackage

// File: rtl/rv_alu_decode.sv
module rv_alu_decode
  import rv_alu_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       alt_sel,
  output alu_kind_e  kind
);
  alu_kind_e arith_kind;
  logic      is_reg;

  assign is_reg = (opcode == OPC_REG);

  always_comb begin
    unique case (funct3)
      3'b000:  arith_kind = (is_reg && alt_sel) ? K_SUB : K_ADD;
      3'b001:  arith_kind = K_SLL;
      3'b010:  arith_kind = K_SLT;
      3'b011:  arith_kind = K_SLTU;
      3'b100:  arith_kind = K_XOR;
      3'b101:  arith_kind = alt_sel ? K_SRA : K_SRL;
      3'b110:  arith_kind = K_OR;
      default: arith_kind = K_AND;
    endcase
  end

  always_comb begin
    unique case (opcode)
      OPC_REG, OPC_IMM:                  kind = arith_kind;
      OPC_LOAD, OPC_STORE, OPC_AUIPC,
      OPC_JAL, OPC_JALR:                 kind = K_ADD;
      OPC_LUI:                           kind = K_PASSB;
      default:                           kind = K_ZERO;
    endcase
  end
endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter
  import rv_alu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [AW-1:0] amt,
  input  logic          to_left,
  input  logic          arith,
  output logic [W-1:0]  shifted
);
  logic [W-1:0] stage [0:AW];
  logic         fill;

  assign stage[0] = to_left ? f_rev(val) : val;
  assign fill     = arith & ~to_left & val[W-1];

  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][W-1:STEP]} : stage[i];
  end

  assign shifted = to_left ? f_rev(stage[AW]) : stage[AW];
endmodule

// File: rtl/rv_alu_datapath.sv
module rv_alu_datapath
  import rv_alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_kind_e     kind,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  y,
  output logic          lt_flag
);
  localparam int AW = $clog2(W);

  logic         do_sub;
  logic [W-1:0] b_eff, sum, sh_out;
  logic         signed_cmp;

  assign do_sub     = (kind == K_SUB);
  assign b_eff      = do_sub ? ~b : b;
  assign sum        = a + b_eff + {{(W-1){1'b0}}, do_sub};
  assign signed_cmp = (kind == K_SLT);
  assign lt_flag    = f_less(a, b, signed_cmp);

  rv_alu_shifter #(.W(W), .AW(AW)) u_shift (
    .val     (a),
    .amt     (b[AW-1:0]),
    .to_left (kind == K_SLL),
    .arith   (kind == K_SRA),
    .shifted (sh_out)
  );

  always_comb begin
    unique case (kind)
      K_ADD, K_SUB:       y = sum;
      K_SLL, K_SRL, K_SRA: y = sh_out;
      K_SLT, K_SLTU:      y = {{(W-1){1'b0}}, lt_flag};
      K_XOR:              y = a ^ b;
      K_OR:               y = a | b;
      K_AND:              y = a & b;
      K_PASSB:            y = b;
      default:            y = '0;
    endcase
  end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
  import rv_alu_pkg::*;
(
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic            alt_sel,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] result
);
  alu_kind_e dec_kind;
  logic      cmp_lt;

  rv_alu_decode u_dec (
    .opcode  (opcode),
    .funct3  (funct3),
    .alt_sel (alt_sel),
    .kind    (dec_kind)
  );

  rv_alu_datapath #(.W(XLEN)) u_dp (
    .kind    (dec_kind),
    .a       (op_a),
    .b       (op_b),
    .y       (result),
    .lt_flag (cmp_lt)
  );
endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk
  import rv_alu_pkg::*;
(
  input logic [6:0]      opcode,
  input logic [2:0]      funct3,
  input logic            alt_sel,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [XLEN-1:0] result,
  input alu_kind_e       dec_kind,
  input logic            cmp_lt
);
  logic known_opc;
  assign known_opc = opcode inside {OPC_REG, OPC_IMM, OPC_LOAD, OPC_STORE,
                                    OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR};

  always_comb begin
    // R7
    a_r7_lui_passes_b: assert (opcode != OPC_LUI || result == op_b);
    // R9
    a_r9_unknown_zero: assert (known_opc || result == '0);
    // R5
    a_r5_lt_single_bit: assert (!(dec_kind inside {K_SLT, K_SLTU})
                                || result == {{(XLEN-1){1'b0}}, cmp_lt});
    // R6
    a_r6_mem_sum: assert (!(opcode inside {OPC_LOAD, OPC_STORE})
                          || result == op_a + op_b);
    // R4
    a_r4_sra_sign_fill: assert (!(dec_kind == K_SRA && op_a[XLEN-1])
                                || result[XLEN-1]);
    // R2
    a_r2_addi_ignores_alt: assert (!(opcode == OPC_IMM && funct3 == 3'b000)
                                   || dec_kind == K_ADD);
    // R1
    a_r1_sub_needs_alt: assert (dec_kind != K_SUB
                                || (alt_sel && opcode == OPC_REG));
  end
endmodule

bind rv_int_alu rv_int_alu_chk u_chk (
  .opcode   (opcode),
  .funct3   (funct3),
  .alt_sel  (alt_sel),
  .op_a     (op_a),
  .op_b     (op_b),
  .result   (result),
  .dec_kind (dec_kind),
  .cmp_lt   (cmp_lt)
);

// File: tb/rv_int_alu_tb.sv
`timescale 1ns/1ps
module rv_int_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic        alt_sel = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] result;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rv_int_alu u_dut (.opcode(opcode), .funct3(funct3), .alt_sel(alt_sel),
                    .op_a(op_a), .op_b(op_b), .result(result));

  function automatic logic [31:0] model(input logic [6:0] oc, input logic [2:0] f3,
                                        input logic alt, input logic [31:0] a,
                                        input logic [31:0] b);
    int unsigned sh;
    sh = b % 32;
    if (oc == 7'b0000011 || oc == 7'b0100011 || oc == 7'b0010111 ||
        oc == 7'b1101111 || oc == 7'b1100111) return a + b;
    if (oc == 7'b0110111) return b;
    if (oc != 7'b0110011 && oc != 7'b0010011) return 32'd0;
    case (f3)
      3'd0: return (alt && oc == 7'b0110011) ? a - b : a + b;
      3'd1: return a << sh;
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: return alt ? 32'($signed(a) >>> sh) : a >> sh;
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  task automatic apply(input logic [6:0] oc, input logic [2:0] f3, input logic alt,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] exp;
    @(posedge clk);
    #1;
    opcode = oc; funct3 = f3; alt_sel = alt; op_a = a; op_b = b;
    exp = model(oc, f3, alt, a, b);
    @(negedge clk);
    n_vec++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s opc=%b f3=%b alt=%b a=%h b=%h actual=%h expected=%h",
               tag, oc, f3, alt, a, b, result, exp);
    end
  endtask

  task automatic expect_const(input logic [31:0] exp, input string tag);
    n_vec++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, result, exp);
    end
  endtask

  function automatic string tag_of(input logic [6:0] oc, input logic [2:0] f3);
    if (oc == 7'b0110011) return "R1";
    if (oc == 7'b0010011) return (f3 == 3'd5) ? "R4" : "R2";
    if (oc == 7'b0000011 || oc == 7'b0100011) return "R6";
    if (oc == 7'b0110111) return "R7";
    if (oc == 7'b0010111 || oc == 7'b1101111 || oc == 7'b1100111) return "R8";
    return "R9";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] opc_set [11];
    opc_set = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b0110111,
                7'b0010111, 7'b1101111, 7'b1100111, 7'b1100011, 7'b1110011, 7'h7f};
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_const(32'd0, "R9 reset-state zero output");
    rst_n = 1'b1;

    apply(7'b0110011, 3'd0, 1'b0, 32'hffffffff, 32'd1, "R1 add wrap");
    apply(7'b0110011, 3'd0, 1'b1, 32'd5, 32'd7, "R1 sub");
    apply(7'b0010011, 3'd0, 1'b1, 32'h80000000, 32'h00000400, "R2 addi alt ignored");
    apply(7'b0010011, 3'd5, 1'b1, 32'h92153524, 32'hffffde81, "R4 srai example");
    apply(7'b0110011, 3'd5, 1'b1, 32'h92153524, 32'hffffde81, "R4 sra example");
    apply(7'b0110011, 3'd5, 1'b0, 32'h92153524, 32'hffffde81, "R4 srl zero fill");
    apply(7'b0110011, 3'd1, 1'b0, 32'h00000001, 32'hffffffe0, "R3 sll upper b ignored");
    apply(7'b0110011, 3'd1, 1'b0, 32'h00000001, 32'd31, "R3 sll max");
    apply(7'b0110011, 3'd5, 1'b1, 32'h80000000, 32'd31, "R4 sra max");
    apply(7'b0110011, 3'd2, 1'b0, 32'hffffffff, 32'd1, "R5 slt signed true");
    apply(7'b0110011, 3'd3, 1'b0, 32'hffffffff, 32'd1, "R5 sltu false");
    apply(7'b0010011, 3'd3, 1'b0, 32'd1, 32'hffffffff, "R5 sltiu true");
    apply(7'b0110011, 3'd2, 1'b0, 32'd4, 32'd4, "R5 slt equal");
    apply(7'b0000011, 3'd4, 1'b1, 32'h1000, 32'hfffffffc, "R6 load sum");
    apply(7'b0100011, 3'd2, 1'b1, 32'h2000, 32'd8, "R6 store sum");
    apply(7'b0110111, 3'd7, 1'b1, 32'h12345678, 32'habcde000, "R7 lui pass");
    apply(7'b0010111, 3'd5, 1'b1, 32'hfffff000, 32'h00002000, "R8 auipc sum");
    apply(7'b1101111, 3'd0, 1'b0, 32'h100, 32'h40, "R8 jal sum");
    apply(7'b1100111, 3'd0, 1'b0, 32'h100, 32'hfffffff0, "R8 jalr sum");
    apply(7'b1100011, 3'd0, 1'b1, 32'h5, 32'h5, "R9 branch zero");
    apply(7'b1111111, 3'd6, 1'b1, 32'hffffffff, 32'hffffffff, "R9 unknown zero");

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] oc;
      logic [2:0] f3;
      oc = opc_set[$urandom % 11];
      f3 = 3'($urandom);
      apply(oc, f3, 1'($urandom), $urandom, $urandom, tag_of(oc, f3));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule